// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Controller

This block keeps two pending bits for each of up to four processors: one for an inter-processor interrupt and one for the interval timer. Each pending bit drives a level interrupt line to its processor. Software changes the pending bits through a small register port. A periodic tick from an external timer marks a timer interrupt pending on every processor at once.

The main entry point is a packed control register. One write to it can raise inter-processor interrupts, drop them and drop timer interrupts for several processors together. Each action has its own four-bit field, with one bit per processor. Three further registers give the same actions one type at a time. Two of them also read back the pending vectors.

A read of the packed register returns the identity of the processor that is asking, together with both pending vectors.

Top module: `ipi_timer_intc`

## Requirements
- R1: After reset, all pending bits, `ipi_irq`, `tmr_irq`, `wr_err`, `rd_valid` and `rdata` are zero.
- R2: A write to address 0 (the control register) acts on processor n through three bit fields. Bit 12+n raises its inter-processor interrupt, bit 8+n drops it, and bit 4+n drops its timer interrupt. All three fields take effect in the same cycle.
- R3: Raising an interrupt that is already pending leaves the state unchanged. Dropping one that is not pending also leaves the state unchanged.
- R4: A cycle with `timer_tick` high sets the timer pending bit of every present processor.
- R5: The dedicated registers take a processor mask in wdata bit n. A write to address 3 raises inter-processor interrupts. A write to address 1 drops inter-processor interrupts. A write to address 2 drops timer interrupts. A read of address 1 returns the inter-processor pending vector in bits 3:0. A read of address 2 returns the timer pending vector in bits 3:0. A read of address 3 returns zero.
- R6: A control-register write with bit 28 set and bits 15:4 clear changes nothing and flags no error. A control-register write with bits 15:4 and bit 28 all clear changes nothing and pulses `wr_err` for one cycle.
- R7: A read of address 0 returns `cpu_id` in bits 1:0, the timer pending vector in bits 7:4 and the inter-processor pending vector in bits 11:8. All other bits are zero.
- R8: Mask bits for processors at index NCPU or above are ignored. Those processors never show a pending bit.
- R9: `ipi_irq` and `tmr_irq` are registered copies of the pending bits, one cycle behind them.
- R10: When a drop and a raise (or a tick) reach the same processor in the same cycle, the drop wins.
- R11: Read data appears with `rd_valid` one cycle after `rd_en`. It shows the state from before any write in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_tick | input | 1 | Periodic timer pulse, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Register select: 0 control, 1 IPI status, 2 timer status, 3 IPI request |
| wdata | input | DW | Write data |
| cpu_id | input | 2 | Number of the processor issuing the access |
| rdata | output | DW | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid |
| wr_err | output | 1 | Pulse on a control write with no recognised field |
| ipi_irq | output | NCPU | Inter-processor interrupt level per processor |
| tmr_irq | output | NCPU | Timer interrupt level per processor |

## Verification
A timer tick can fall in the same cycle as a software drop of timer interrupts. A raise and a drop of the same inter-processor interrupt can also fall in one cycle, when both fields are set in a single control word. The bench raises the tick during a write to the timer status register, and it writes control words that set both the raise and drop bits for one processor. It then judges the outcome from the interrupt lines and from the read-back vectors. The dropped processor must stay clear, while the processors that are only ticked or only raised must become pending.

// File: rtl/ipi_timer_intc.sv
module ipi_timer_intc #(
  parameter int NCPU = 4,
  parameter int DW   = 32,
  parameter int AW   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            timer_tick,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic [1:0]      cpu_id,
  output logic [DW-1:0]   rdata,
  output logic            rd_valid,
  output logic            wr_err,
  output logic [NCPU-1:0] ipi_irq,
  output logic [NCPU-1:0] tmr_irq
);
  localparam logic [AW-1:0] A_CTRL    = AW'(0);
  localparam logic [AW-1:0] A_IPISTAT = AW'(1);
  localparam logic [AW-1:0] A_TMRSTAT = AW'(2);
  localparam logic [AW-1:0] A_IPIREQ  = AW'(3);
  localparam int RAISE_LSB = 12;
  localparam int DROP_LSB  = 8;
  localparam int TDROP_LSB = 4;
  localparam int IGNORE_BIT = 28;

  logic [NCPU-1:0] ipi_pend, tmr_pend;
  logic [NCPU-1:0] ipi_set, ipi_clr, tmr_set, tmr_clr;
  logic [3:0]      ipi_vec, tmr_vec;
  logic [DW-1:0]   rd_mux;
  logic            past_ok;

  wire ctrl_wr  = wr_en && (addr == A_CTRL);
  wire ctrl_hit = (|wdata[15:4]) || wdata[IGNORE_BIT];

  assign ipi_set = ctrl_wr ? wdata[RAISE_LSB +: NCPU] :
                   (wr_en && addr == A_IPIREQ) ? wdata[NCPU-1:0] : '0;
  assign ipi_clr = ctrl_wr ? wdata[DROP_LSB +: NCPU] :
                   (wr_en && addr == A_IPISTAT) ? wdata[NCPU-1:0] : '0;
  assign tmr_clr = ctrl_wr ? wdata[TDROP_LSB +: NCPU] :
                   (wr_en && addr == A_TMRSTAT) ? wdata[NCPU-1:0] : '0;
  assign tmr_set = {NCPU{timer_tick}};

  assign ipi_vec = 4'(ipi_pend);
  assign tmr_vec = 4'(tmr_pend);

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_CTRL:    rd_mux = DW'({ipi_vec, tmr_vec, 2'b00, cpu_id});
      A_IPISTAT: rd_mux = DW'(ipi_vec);
      A_TMRSTAT: rd_mux = DW'(tmr_vec);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ipi_pend <= '0;
      tmr_pend <= '0;
      ipi_irq  <= '0;
      tmr_irq  <= '0;
      wr_err   <= 1'b0;
      rd_valid <= 1'b0;
      rdata    <= '0;
      past_ok  <= 1'b0;
    end else begin
      ipi_pend <= (ipi_pend | ipi_set) & ~ipi_clr;
      tmr_pend <= (tmr_pend | tmr_set) & ~tmr_clr;
      ipi_irq  <= ipi_pend;
      tmr_irq  <= tmr_pend;
      wr_err   <= ctrl_wr && !ctrl_hit;
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_mux;
      past_ok  <= 1'b1;
    end
  end

  AST_DROP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ipi_clr != '0) |=> ((ipi_pend & $past(ipi_clr)) == '0)); // R10

  AST_TICK_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_tick && tmr_clr == '0) |=> (&tmr_pend)); // R4

  AST_RAISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ((ipi_set & ~ipi_clr) != '0) |=> ((ipi_pend & $past(ipi_set & ~ipi_clr)) == $past(ipi_set & ~ipi_clr))); // R2

  AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && wr_err) |-> $past(wr_en && addr == A_CTRL)); // R6

  AST_ERR_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && wr_err && !$past(timer_tick)) |-> ($stable(ipi_pend) && $stable(tmr_pend))); // R6

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((ipi_irq & ~$past(ipi_irq) & ~$past(ipi_pend)) == '0)); // R9

  AST_RD_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && rd_valid) |-> $past(rd_en)); // R11
endmodule

// File: tb/ipi_timer_intc_tb.sv
module ipi_timer_intc_tb;
  localparam int NCPU = 3;
  localparam int DW = 32;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic timer_tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [1:0] cpu_id = '0;
  logic [DW-1:0] rdata;
  logic rd_valid, wr_err;
  logic [NCPU-1:0] ipi_irq, tmr_irq;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  ipi_timer_intc #(.NCPU(NCPU), .DW(DW), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .timer_tick(timer_tick), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .cpu_id(cpu_id),
    .rdata(rdata), .rd_valid(rd_valid), .wr_err(wr_err),
    .ipi_irq(ipi_irq), .tmr_irq(tmr_irq));

  always @(negedge clk) begin
    if (rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected read data got %h expected none", rdata);
      end else begin
        automatic logic [DW-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s read got %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic rd(input logic [AW-1:0] a, input logic [1:0] cpu, input logic [DW-1:0] e, input string t);
    @(negedge clk);
    rd_en = 1'b1; addr = a; cpu_id = cpu;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic tick);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; timer_tick = tick;
    @(negedge clk);
    wr_en = 1'b0; timer_tick = 1'b0;
  endtask

  task automatic chk(input string t, input logic [31:0] got, input logic [31:0] e);
    checks++;
    if (got !== e) begin
      errors++;
      $display("FAIL %s got %h expected %h", t, got, e);
    end
  endtask

  task automatic chk_irq(input logic [NCPU-1:0] ei, input logic [NCPU-1:0] et, input string t);
    @(negedge clk);
    chk({t, " ipi_irq"}, 32'(ipi_irq), 32'(ei));
    chk({t, " tmr_irq"}, 32'(tmr_irq), 32'(et));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 ipi_irq", 32'(ipi_irq), 0);
    chk("R1 tmr_irq", 32'(tmr_irq), 0);
    chk("R1 wr_err", 32'(wr_err), 0);
    chk("R1 rdata", rdata, 0);
    rd(2'd0, 2'd2, 32'h2, "R1/R7 ctrl after reset");
    rd(2'd1, 2'd0, 32'h0, "R1 ipi status after reset");

    wr(2'd0, 32'h0, 1'b1); // R4 tick rides on a control write of zero
    chk("R6 wr_err on empty control write", 32'(wr_err), 1);
    @(negedge clk);
    chk("R6 wr_err one cycle", 32'(wr_err), 0);
    chk("R4/R9 tmr_irq after tick", 32'(tmr_irq), 32'h7);
    rd(2'd2, 2'd0, 32'h7, "R4 timer status");

    wr(2'd0, 32'h5000, 1'b0); // R2 raise cpu0, cpu2
    chk("R2 no err", 32'(wr_err), 0);
    chk_irq(3'b101, 3'b111, "R2/R9");
    wr(2'd0, 32'h1000, 1'b0); // R3 redundant raise
    wr(2'd0, 32'h0200, 1'b0); // R3 drop not pending
    chk_irq(3'b101, 3'b111, "R3");
    wr(2'd0, 32'h8000, 1'b0); // R8 absent cpu3
    rd(2'd1, 2'd0, 32'h5, "R8 absent cpu ignored");
    wr(2'd0, 32'h2200, 1'b0); // R10 raise and drop cpu1
    rd(2'd1, 2'd0, 32'h5, "R10 drop beats raise");
    wr(2'd0, 32'h2100, 1'b0); // raise cpu1, drop cpu0
    wr(2'd0, 32'h0020, 1'b0); // drop timer cpu1
    chk_irq(3'b110, 3'b101, "R2 fields");
    rd(2'd0, 2'd1, 32'h651, "R7 ctrl read");
    wr(2'd0, 32'h1000_0000, 1'b0);
    chk("R6 ignored bit no err", 32'(wr_err), 0);
    rd(2'd0, 2'd0, 32'h650, "R6 ignored bit no change");

    wr(2'd3, 32'hF, 1'b0);
    wr(2'd1, 32'hA, 1'b0);
    wr(2'd2, 32'h1, 1'b0);
    rd(2'd1, 2'd0, 32'h5, "R5 ipi status");
    rd(2'd2, 2'd0, 32'h4, "R5 timer status");
    rd(2'd3, 2'd0, 32'h0, "R5 request reads zero");

    wr(2'd2, 32'h4, 1'b1); // R10 tick with timer drop of cpu2
    chk_irq(3'b101, 3'b011, "R10 tick vs drop");

    @(negedge clk);
    rd_en = 1'b1; wr_en = 1'b1; addr = 2'd1; wdata = 32'h1;
    exp_q.push_back(32'h5); tag_q.push_back("R11 read before same-cycle write");
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    rd(2'd1, 2'd0, 32'h4, "R11 write landed");

    repeat (3) @(negedge clk);
    chk("R11 scoreboard drained", 32'(exp_q.size()), 0);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule